// File: doc/BRIEF.md
# Stop-Mode Wakeup Timer Controller

This block sequences entry into and exit from a low-power stop state for a small controller. It holds two cascaded 8-bit down-counters, a clock control register and a timer mode register. All four are reachable over a simple register write bus and are always visible on read-back ports. A stop strobe gates the system clock off. In the same edge it presets both counters and restarts their count chain, so that a later wakeup takes a fixed, known time.

A wake event does not reopen the clock directly. It starts a settling count. A divide-by-8 prescaler steps the first counter. Each wrap of the first counter steps the second counter. When the second counter underflows, the clock enable returns and the clock-enable bit of the control register is set again. The settling time from the wake edge is 2 × 256 × 8 = 4096 cycles.

The controller is a three-state machine:
- RUN: the clock is on and the bus is live.
- STOPPED: the clock is off and the block waits for a wake event.
- SETTLE: the clock is off and the counter chain is running.

Transitions:
- RUN→STOPPED on a stop strobe.
- STOPPED→SETTLE on a wake event.
- SETTLE→RUN on underflow of the second counter.
- SETTLE→STOPPED on a stop strobe.
- Any state→RUN on reset.

Top module: `stopwake_ctrl`

## Requirements
- R1: Synchronous active-high reset sets counter 1 = 0xFF, counter 2 = 0x01, mode = 0x00, control = 0x80, and sys_clk_en = 1 (state RUN).
- R2: In RUN, a write with wr_en stores wr_data at the addressed register: address 0 = counter 1, address 1 = counter 2, address 2 = mode, address 3 = control bits 6:0. Control bit 7 is not writable from the bus. Outside writes, the counters hold their value in RUN.
- R3: A stop strobe takes effect on the next edge: sys_clk_en and control bit 7 fall to 0, and control bits 6:0 are kept.
- R4: A stop strobe loads counter 1 with 0xFF and counter 2 with 0x01, and restarts the divide-by-8 prescaler.
- R5: A stop strobe clears every mode bit except bit 4, whatever value the count-stop bit (bit 1) holds.
- R6: Bus writes have no effect when the state is not RUN, or in any cycle where stop_req is high.
- R7: STOPPED persists with no time limit until wake_evt. A wake_evt seen in RUN has no effect.
- R8: In SETTLE, counter 1 decrements once every 8 cycles. When it steps from 0x00 it reloads 0xFF and decrements counter 2.
- R9: When counter 2 underflows, sys_clk_en and control bit 7 return to 1 exactly 4096 cycles after the edge that sampled wake_evt. At that point counter 1 = 0xFF and counter 2 = 0xFF.
- R10: A stop strobe in SETTLE wins over a coincident underflow. The block returns to STOPPED with the R4/R5 presets.
- R11: Reset overrides stop, wake and writes in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wakeup clock; always running |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 cnt1, 1 cnt2, 2 mode, 3 control) |
| wr_data | input | 8 | Write data |
| stop_req | input | 1 | Stop strobe |
| wake_evt | input | 1 | Wake event; starts settling |
| sys_clk_en | output | 1 | System clock gate enable |
| rd_t1 | output | 8 | Counter 1 value |
| rd_t2 | output | 8 | Counter 2 value |
| rd_mode | output | 8 | Mode register value |
| rd_ctrl | output | 8 | Clock control register value |

## Verification
Two pairs of events can fall on the same edge. A stop strobe can coincide with a bus write, and a stop strobe can coincide with the underflow that would end settling. The bench drives a random write in the very cycle of each stop strobe. It also places one stop exactly on edge 4096 after a wake. The outcome is judged at the ports. In the write case, the mode register must equal the pre-stop value masked to bit 4 with the write lost. In the underflow case, the clock must stay off and the counters must show the stop presets rather than the wrapped wake values.

// File: rtl/swk_pkg.sv
package swk_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_SETTLE  = 2'd2
    } swk_state_e;

    localparam logic [1:0] ADDR_T1   = 2'd0;
    localparam logic [1:0] ADDR_T2   = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;
endpackage

// File: rtl/swk_prescaler.sv
module swk_prescaler #(
    parameter int W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == {W{1'b1}});
endmodule

// File: rtl/swk_timer_chain.sv
module swk_timer_chain #(
    parameter int          TW  = 8,
    parameter logic [TW-1:0] T1P = 8'hFF,
    parameter logic [TW-1:0] T2P = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          preset,
    input  logic          wr_t1,
    input  logic          wr_t2,
    input  logic [TW-1:0] wr_data,
    input  logic          tick,
    output logic [TW-1:0] t1,
    output logic [TW-1:0] t2,
    output logic          chain_uf
);
    localparam logic [TW-1:0] ALL1 = {TW{1'b1}};

    logic [TW-1:0] t1_q, t2_q;
    logic          t1_wrap;

    assign t1_wrap  = tick && (t1_q == '0);
    assign chain_uf = t1_wrap && (t2_q == '0);

    // stage 1: steps on prescaler ticks, reloads all ones on wrap
    always_ff @(posedge clk) begin
        if (rst || preset) begin
            t1_q <= T1P;
        end else if (wr_t1) begin
            t1_q <= wr_data;
        end else if (t1_wrap) begin
            t1_q <= ALL1;
        end else if (tick) begin
            t1_q <= t1_q - 1'b1;
        end
    end

    // stage 2: steps once per stage-1 wrap
    always_ff @(posedge clk) begin
        if (rst || preset) begin
            t2_q <= T2P;
        end else if (wr_t2) begin
            t2_q <= wr_data;
        end else if (t1_wrap) begin
            t2_q <= t2_q - 1'b1;
        end
    end

    assign t1 = t1_q;
    assign t2 = t2_q;
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
    import swk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       wake_evt,
    input  logic       chain_uf,
    output logic       clk_en,
    output logic       do_stop,
    output logic       do_wake,
    output logic       count_en,
    output logic       wr_ok
);
    swk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req) state_d = ST_STOPPED;
            end
            ST_STOPPED: begin
                if (!stop_req && wake_evt) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (stop_req)      state_d = ST_STOPPED;
                else if (chain_uf) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        clk_en   = 1'b0;
        count_en = 1'b0;
        wr_ok    = 1'b0;
        do_wake  = 1'b0;
        do_stop  = stop_req;
        unique case (state_q)
            ST_RUN: begin
                clk_en = 1'b1;
                wr_ok  = !stop_req;
            end
            ST_STOPPED: begin
            end
            ST_SETTLE: begin
                count_en = !stop_req;
                do_wake  = !stop_req && chain_uf;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
    import swk_pkg::*;
#(
    parameter int            TW        = 8,
    parameter int            PRESC_W   = 3,
    parameter logic [TW-1:0] T1_PRESET = 8'hFF,
    parameter logic [TW-1:0] T2_PRESET = 8'h01,
    parameter logic [TW-1:0] MODE_KEEP = 8'h10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic          stop_req,
    input  logic          wake_evt,
    output logic          sys_clk_en,
    output logic [TW-1:0] rd_t1,
    output logic [TW-1:0] rd_t2,
    output logic [TW-1:0] rd_mode,
    output logic [TW-1:0] rd_ctrl
);
    localparam int CEN = TW - 1;

    logic clk_en, do_stop, do_wake, count_en, wr_ok;
    logic tick, chain_uf;
    logic wr_t1, wr_t2, wr_mode, wr_ctrl;
    logic [TW-1:0] mode_q, ctrl_q;

    assign wr_t1   = wr_ok && wr_en && (wr_addr == ADDR_T1);
    assign wr_t2   = wr_ok && wr_en && (wr_addr == ADDR_T2);
    assign wr_mode = wr_ok && wr_en && (wr_addr == ADDR_MODE);
    assign wr_ctrl = wr_ok && wr_en && (wr_addr == ADDR_CTRL);

    swk_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .stop_req (stop_req),
        .wake_evt (wake_evt),
        .chain_uf (chain_uf),
        .clk_en   (clk_en),
        .do_stop  (do_stop),
        .do_wake  (do_wake),
        .count_en (count_en),
        .wr_ok    (wr_ok)
    );

    swk_prescaler #(.W(PRESC_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (do_stop),
        .en   (count_en),
        .tick (tick)
    );

    swk_timer_chain #(.TW(TW), .T1P(T1_PRESET), .T2P(T2_PRESET)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .preset   (do_stop),
        .wr_t1    (wr_t1),
        .wr_t2    (wr_t2),
        .wr_data  (wr_data),
        .tick     (tick),
        .t1       (rd_t1),
        .t2       (rd_t2),
        .chain_uf (chain_uf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (do_stop) begin
            mode_q <= mode_q & MODE_KEEP;
        end else if (wr_mode) begin
            mode_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= {1'b1, {(TW-1){1'b0}}};
        end else begin
            if (do_stop)      ctrl_q[CEN] <= 1'b0;
            else if (do_wake) ctrl_q[CEN] <= 1'b1;
            if (wr_ctrl)      ctrl_q[CEN-1:0] <= wr_data[CEN-1:0];
        end
    end

    assign sys_clk_en = clk_en;
    assign rd_mode    = mode_q;
    assign rd_ctrl    = ctrl_q;
endmodule

// File: rtl/stopwake_checker.sv
module stopwake_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       stop_req,
    input logic       wake_evt,
    input logic       sys_clk_en,
    input logic [7:0] rd_t1,
    input logic [7:0] rd_t2,
    input logic [7:0] rd_mode,
    input logic [7:0] rd_ctrl
);
    p_clk_en_tracks_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
        sys_clk_en == rd_ctrl[7]);

    p_stop_presets_r4: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (!sys_clk_en && rd_t1 == 8'hFF && rd_t2 == 8'h01));

    p_stop_mode_mask_r5: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> rd_mode == ($past(rd_mode) & 8'h10));

    p_no_write_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!sys_clk_en && !stop_req) |=> ($stable(rd_mode) && $stable(rd_ctrl[6:0])));

    p_run_timers_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (sys_clk_en && !wr_en && !stop_req) |=> ($stable(rd_t1) && $stable(rd_t2)));

    p_wake_not_instant_r7: assert property (@(posedge clk) disable iff (rst)
        (!sys_clk_en && wake_evt && !stop_req && rd_t1 == 8'hFF && rd_t2 == 8'h01)
        |=> !sys_clk_en);

    p_t2_steps_on_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (!sys_clk_en && !stop_req && rd_t1 != 8'h00) |=> $stable(rd_t2));
endmodule

bind stopwake_ctrl stopwake_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .stop_req   (stop_req),
    .wake_evt   (wake_evt),
    .sys_clk_en (sys_clk_en),
    .rd_t1      (rd_t1),
    .rd_t2      (rd_t2),
    .rd_mode    (rd_mode),
    .rd_ctrl    (rd_ctrl)
);

// File: tb/tb_stopwake_ctrl.sv
`timescale 1ns/1ps
module tb_stopwake_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       stop_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       sys_clk_en;
    logic [7:0] rd_t1, rd_t2, rd_mode, rd_ctrl;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] m_t1, m_t2, m_mode, m_ctrl;

    always #2 clk = ~clk;

    stopwake_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stop_req(stop_req), .wake_evt(wake_evt), .sys_clk_en(sys_clk_en),
        .rd_t1(rd_t1), .rd_t2(rd_t2), .rd_mode(rd_mode), .rd_ctrl(rd_ctrl)
    );

    localparam int WAKE_CYC = 2 * 256 * 8;

    function automatic logic [7:0] exp_t1_at(int n);
        int k = n / 8;
        if (k < 256) return 8'(255 - k);
        return 8'(255 - (k - 256));
    endfunction

    function automatic logic [7:0] exp_t2_at(int n);
        return ((n / 8) < 256) ? 8'h01 : 8'h00;
    endfunction

    function automatic logic [7:0] masked_mode(logic [7:0] m);
        return m & 8'h10;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check_all(string tag, logic en);
        chk({tag, " clk_en"}, {7'd0, sys_clk_en}, {7'd0, en});
        chk({tag, " t1"}, rd_t1, m_t1);
        chk({tag, " t2"}, rd_t2, m_t2);
        chk({tag, " mode"}, rd_mode, m_mode);
        chk({tag, " ctrl"}, rd_ctrl, m_ctrl);
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d, logic running);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
        if (running) begin
            case (a)
                2'd0: m_t1 = d;
                2'd1: m_t2 = d;
                2'd2: m_mode = d;
                default: m_ctrl = {m_ctrl[7], d[6:0]};
            endcase
        end
    endtask

    task automatic do_stop(logic with_wr, logic [1:0] a, logic [7:0] d);
        stop_req = 1'b1;
        if (with_wr) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
        cyc();
        stop_req = 1'b0; wr_en = 1'b0;
        m_t1 = 8'hFF; m_t2 = 8'h01;
        m_mode = masked_mode(m_mode);
        m_ctrl = {1'b0, m_ctrl[6:0]};
    endtask

    task automatic do_wake();
        wake_evt = 1'b1;
        cyc();
        wake_evt = 1'b0;
    endtask

    task automatic wait_run(string tag);
        int n = 0;
        while (!sys_clk_en && n < 10000) begin
            cyc();
            n++;
        end
        chk({tag, " R9 latency lo"}, 8'(n), 8'(WAKE_CYC));
        chk({tag, " R9 latency hi"}, 8'(n >> 8), 8'(WAKE_CYC >> 8));
        m_t1 = 8'hFF; m_t2 = 8'hFF;
        m_ctrl = {1'b1, m_ctrl[6:0]};
        check_all({tag, " R9 woke"}, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd7741);
        m_t1 = 8'hFF; m_t2 = 8'h01; m_mode = 8'h00; m_ctrl = 8'h80;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        check_all("R1 reset", 1'b1);

        // R2: directed writes, control bit 7 not writable
        bus_write(2'd2, 8'hFF, 1'b1);
        bus_write(2'd3, 8'h00, 1'b1);
        bus_write(2'd0, 8'h3C, 1'b1);
        bus_write(2'd1, 8'hA5, 1'b1);
        check_all("R2 writes", 1'b1);

        // R7: wake while running is ignored
        do_wake();
        cyc();
        check_all("R7 wake in run", 1'b1);

        // R3 R4 R5: stop with count-stop bit set
        do_stop(1'b0, 2'd0, 8'd0);
        check_all("R3 R4 R5 stop", 1'b0);

        // R6: writes while stopped are ignored
        bus_write(2'd2, 8'h5A, 1'b0);
        bus_write(2'd3, 8'h7F, 1'b0);
        bus_write(2'd0, 8'h12, 1'b0);
        check_all("R6 stopped writes", 1'b0);

        // R7: stays stopped without wake
        repeat (5000) cyc();
        check_all("R7 hold", 1'b0);

        // R8: mid-settle counter values
        do_wake();
        repeat (100) cyc();
        chk("R8 t1 at 100", rd_t1, exp_t1_at(100));
        chk("R8 t2 at 100", rd_t2, exp_t2_at(100));
        repeat (2000) cyc();
        chk("R8 t1 at 2100", rd_t1, exp_t1_at(2100));
        chk("R8 t2 at 2100", rd_t2, exp_t2_at(2100));
        bus_write(2'd2, 8'hEE, 1'b0);
        chk("R6 settle write", rd_mode, m_mode);
        // remaining cycles counted from here: 2101 already spent
        begin
            int n = 2101;
            while (!sys_clk_en && n < 10000) begin cyc(); n++; end
            chk("R9 latency lo", 8'(n), 8'(WAKE_CYC));
            chk("R9 latency hi", 8'(n >> 8), 8'(WAKE_CYC >> 8));
        end
        m_t1 = 8'hFF; m_t2 = 8'hFF; m_ctrl = {1'b1, m_ctrl[6:0]};
        check_all("R9 after wake", 1'b1);

        // R10: stop coincident with the underflow edge
        do_stop(1'b0, 2'd0, 8'd0);
        do_wake();
        repeat (WAKE_CYC - 1) cyc();
        chk("R10 pre-edge off", {7'd0, sys_clk_en}, 8'd0);
        do_stop(1'b0, 2'd0, 8'd0);
        check_all("R10 stop wins underflow", 1'b0);
        repeat (20) cyc();
        check_all("R10 stays stopped", 1'b0);

        // R11: reset in settle
        do_wake();
        repeat (300) cyc();
        rst = 1'b1; stop_req = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h77;
        cyc();
        rst = 1'b0; stop_req = 1'b0; wr_en = 1'b0;
        m_t1 = 8'hFF; m_t2 = 8'h01; m_mode = 8'h00; m_ctrl = 8'h80;
        check_all("R11 reset override", 1'b1);

        // random rounds: writes, stop with coincident write, stopped writes, wake
        for (int r = 0; r < 6; r++) begin
            for (int w = 0; w < 6; w++)
                bus_write(2'($urandom_range(0, 3)), 8'($urandom), 1'b1);
            check_all("R2 random", 1'b1);
            do_stop(1'b1, 2'($urandom_range(0, 3)), 8'($urandom));
            check_all("R6 R5 stop+write", 1'b0);
            for (int w = 0; w < 3; w++)
                bus_write(2'($urandom_range(0, 3)), 8'($urandom), 1'b0);
            repeat ($urandom_range(1, 40)) cyc();
            check_all("R6 random stopped", 1'b0);
            do_wake();
            wait_run("random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule